// File: doc/BRIEF.md
# Transmit retry-over statistics counter

This block keeps a statistic of outgoing frames that a transmitter gives up on. It follows the attempts made for the frame currently being sent. One pulse on the failure strobe marks one failed attempt; the first transfer and each retransfer count alike. When the sixteenth failure arrives for the same frame, the frame is counted as abandoned. A success strobe or a new-frame strobe starts the attempt tally over.

The number of abandoned frames is kept in a 16-bit field, which sits in the low half of a 32-bit register. The field saturates at its maximum value and does not wrap. Software reads it over a simple strobe-based register bus. A mode bit selects how the count is cleared. With the bit at 1, every read clears it. With the bit at 0, only a write of one fixed data word clears it. The register value is always present on the read-data output.

Top module: `tx_abandon_counter`

## Requirements
- R1: rd_data_o[15:0] carries the abandon count and rd_data_o[31:16] is always zero; no write changes the upper half.
- R2: A frame is abandoned on the 16th failure strobe since the attempt tally last restarted. The tally restarts on reset, on a success strobe, on a new-frame strobe or after an abandon. A failure strobe in the same cycle as a success or new-frame strobe is discarded.
- R3: Each abandon raises the count by exactly one. The new value shows on rd_data_o after the clock edge that samples the 16th failure strobe.
- R4: The count saturates at all ones of its width (0xFFFF by default). Further abandons leave it unchanged.
- R5: With clr_on_read_i = 1, a cycle with rd_en_i high shows the pre-clear count on rd_data_o, and the count is zero after that edge.
- R6: With clr_on_read_i = 0, reads leave the count unchanged. A write whose wr_data_i equals 0x11111111 clears the count to zero at that edge.
- R7: With clr_on_read_i = 0, a write of any other data has no effect. With clr_on_read_i = 1, every write is ignored.
- R8: Reset (rst_n low) sets both the count and the attempt tally to zero.
- R9: When an abandon and a clear fall in the same cycle, the count becomes 1 after that edge. No abandon is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attempt_fail_i | input | 1 | One transmission attempt failed |
| frame_ok_i | input | 1 | Current frame sent successfully |
| frame_start_i | input | 1 | A new frame begins |
| clr_on_read_i | input | 1 | 1: clear on read; 0: clear by pattern write |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register value: zero upper half, count in lower half |

## Verification
The read-data output follows the count register directly. A read therefore shows the pre-clear value in the same cycle as its strobe. Every count change, whether from an abandon or a clear, shows one edge after the strobe that causes it. The bench drives inputs at the falling edge and samples the next value at the following falling edge. It samples the same-cycle read value one time unit after driving the strobe, before the rising edge. Saturation is checked on a second instance with a 4-bit count, which reaches its ceiling in a few hundred cycles.

// File: rtl/tac_pkg.sv
package tac_pkg;
    typedef enum logic {
        CLR_BY_PATTERN = 1'b0,
        CLR_BY_READ    = 1'b1
    } clr_mode_e;

    localparam logic [31:0] DEFAULT_CLEAR_WORD = 32'h1111_1111;
endpackage

// File: rtl/tac_attempt_track.sv
module tac_attempt_track #(
    parameter int ATTEMPT_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic ok_i,
    input  logic start_i,
    output logic abandon_o
);
    localparam int AW = (ATTEMPT_LIMIT > 2) ? $clog2(ATTEMPT_LIMIT) : 1;
    localparam logic [AW-1:0] LAST = AW'(ATTEMPT_LIMIT - 1);

    typedef struct packed {
        logic [AW-1:0] tries;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        abandon_o = 1'b0;
        if (ok_i || start_i) begin
            trk_d.tries = '0;
        end else if (fail_i) begin
            if (trk_q.tries == LAST) begin
                abandon_o   = 1'b1;
                trk_d.tries = '0;
            end else begin
                trk_d.tries = trk_q.tries + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/tac_clear_decode.sv
module tac_clear_decode
    import tac_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] CLEAR_WORD = DEFAULT_CLEAR_WORD
) (
    input  clr_mode_e         mode_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              clear_o
);
    localparam logic [DATA_W-1:0] MATCH = DATA_W'(CLEAR_WORD);

    always_comb begin
        unique case (mode_i)
            CLR_BY_READ:    clear_o = rd_i;
            CLR_BY_PATTERN: clear_o = wr_i && (wdata_i == MATCH);
            default:        clear_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tac_sat_count.sv
module tac_sat_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abandon_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CEIL = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d.cnt = abandon_i ? CNT_W'(1) : '0;
        end else if (abandon_i && (cnt_q.cnt != CEIL)) begin
            cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q.cnt;
endmodule

// File: rtl/tx_abandon_counter.sv
module tx_abandon_counter
    import tac_pkg::*;
#(
    parameter int          ATTEMPT_LIMIT = 16,
    parameter int          CNT_W         = 16,
    parameter int          DATA_W        = 32,
    parameter logic [31:0] CLEAR_WORD    = DEFAULT_CLEAR_WORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attempt_fail_i,
    input  logic              frame_ok_i,
    input  logic              frame_start_i,
    input  logic              clr_on_read_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic             abandon;
    logic             clear;
    logic [CNT_W-1:0] count;
    clr_mode_e        mode;

    assign mode = clr_mode_e'(clr_on_read_i);

    tac_attempt_track #(.ATTEMPT_LIMIT(ATTEMPT_LIMIT)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_i    (attempt_fail_i),
        .ok_i      (frame_ok_i),
        .start_i   (frame_start_i),
        .abandon_o (abandon)
    );

    tac_clear_decode #(.DATA_W(DATA_W), .CLEAR_WORD(CLEAR_WORD)) u_clr (
        .mode_i  (mode),
        .rd_i    (rd_en_i),
        .wr_i    (wr_en_i),
        .wdata_i (wr_data_i),
        .clear_o (clear)
    );

    tac_sat_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .abandon_i (abandon),
        .clear_i   (clear),
        .count_o   (count)
    );

    assign rd_data_o = {{PAD_W{1'b0}}, count};
endmodule

// File: rtl/tx_abandon_counter_chk.sv
module tx_abandon_counter_chk #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fail,
    input logic              ok,
    input logic              start,
    input logic              mode,
    input logic              rd_en,
    input logic              wr_en,
    input logic              abandon,
    input logic              clear,
    input logic [CNT_W-1:0]  count,
    input logic [DATA_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] CEIL = '1;

    // R1: upper half stays zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:CNT_W] == '0);

    // R2: an abandon needs a live failure strobe without a restart
    a_r2_abandon_cause: assert property (@(posedge clk) disable iff (!rst_n)
        abandon |-> (fail && !ok && !start));

    // R3: without a clear the count steps by at most one
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    // R4: saturation holds
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CEIL && !clear) |=> count == CEIL);

    // R5/R6: a clear with no abandon yields zero
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !abandon) |=> count == '0);

    // R6: pattern mode reads leave the count alone
    a_r6_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && rd_en && !wr_en && !abandon) |=> $stable(count));

    // R7: clear-on-read mode ignores writes
    a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && wr_en && !rd_en && !abandon) |=> $stable(count));

    // R9: clear and abandon together give one
    a_r9_clear_and_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && abandon) |=> count == CNT_W'(1));
endmodule

bind tx_abandon_counter tx_abandon_counter_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fail    (attempt_fail_i),
    .ok      (frame_ok_i),
    .start   (frame_start_i),
    .mode    (clr_on_read_i),
    .rd_en   (rd_en_i),
    .wr_en   (wr_en_i),
    .abandon (abandon),
    .clear   (clear),
    .count   (count),
    .rd_data (rd_data_o)
);

// File: tb/tx_abandon_counter_test.sv
module tx_abandon_counter_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fail = 1'b0, ok = 1'b0, start = 1'b0, mode = 1'b0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sat_fail = 1'b0;
    logic [31:0] sat_rdata;

    int n_run = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    tx_abandon_counter uut (
        .clk(clk), .rst_n(rst_n), .attempt_fail_i(fail), .frame_ok_i(ok),
        .frame_start_i(start), .clr_on_read_i(mode), .rd_en_i(rd),
        .wr_en_i(wr), .wr_data_i(wdata), .rd_data_o(rdata)
    );

    tx_abandon_counter #(.CNT_W(4)) uut_sat (
        .clk(clk), .rst_n(rst_n), .attempt_fail_i(sat_fail), .frame_ok_i(1'b0),
        .frame_start_i(1'b0), .clr_on_read_i(1'b0), .rd_en_i(1'b0),
        .wr_en_i(1'b0), .wr_data_i(32'h0), .rd_data_o(sat_rdata)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  reps;
        logic        f, k, s, m, r, w;
        logic [31:0] wd;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{8'd2, 8'd15, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd0}, // R2 not yet
        '{8'd3, 8'd1,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd1}, // R3 16th
        '{8'd2, 8'd16, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd2}, // R2 restart after abandon
        '{8'd2, 8'd10, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd2},
        '{8'd2, 8'd1,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd2}, // R2 success restarts
        '{8'd2, 8'd15, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd2},
        '{8'd3, 8'd1,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd3},
        '{8'd2, 8'd5,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd3},
        '{8'd2, 8'd1,  1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,        16'd3}, // R2 new frame restarts
        '{8'd2, 8'd15, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd3},
        '{8'd2, 8'd1,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd3}, // R2 fail with ok discarded
        '{8'd3, 8'd16, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd4},
        '{8'd6, 8'd1,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0,        16'd4}, // R6 read keeps
        '{8'd7, 8'd1,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h1111_1110, 16'd4}, // R7 near miss
        '{8'd1, 8'd1,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 32'hFFFF_0000, 16'd4}, // R1 upper write
        '{8'd6, 8'd1,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h1111_1111, 16'd0}, // R6 pattern clears
        '{8'd3, 8'd16, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,        16'd1},
        '{8'd7, 8'd1,  1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 32'h1111_1111, 16'd1}, // R7 mode 1 write
        '{8'd5, 8'd1,  1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0,        16'd0}  // R5 read clears
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        fail = 1'b0; ok = 1'b0; start = 1'b0; rd = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(8, rdata, 32'h0);                    // R8 reset value
        check(8, sat_rdata, 32'h0);                // R8 second instance

        for (int i = 0; i < NV; i++) begin
            mode = VECS[i].m;
            for (int j = 0; j < int'(VECS[i].reps); j++) begin
                fail = VECS[i].f; ok = VECS[i].k; start = VECS[i].s;
                rd = VECS[i].r; wr = VECS[i].w; wdata = VECS[i].wd;
                @(negedge clk);
            end
            idle();
            check(int'(VECS[i].req), rdata, {16'h0, VECS[i].exp});
        end

        // R5 + R9: same-cycle value and clear with abandon (mode 1, count 0)
        mode = 1'b1;
        repeat (16) begin fail = 1'b1; @(negedge clk); end
        repeat (15) begin fail = 1'b1; @(negedge clk); end
        fail = 1'b1; rd = 1'b1;
        #1;
        check(5, rdata, 32'h1);                    // R5 pre-clear value shown
        @(negedge clk);
        idle();
        check(9, rdata, 32'h1);                    // R9 clear and abandon give one

        // R6 + R9 in pattern mode
        mode = 1'b0;
        repeat (15) begin fail = 1'b1; @(negedge clk); end
        fail = 1'b1; wr = 1'b1; wdata = 32'h1111_1111;
        @(negedge clk);
        idle();
        check(9, rdata, 32'h1);                    // R9 with pattern write

        // R8: reset clears count and attempt tally
        repeat (15) begin fail = 1'b1; @(negedge clk); end
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(8, rdata, 32'h0);
        fail = 1'b1;
        @(negedge clk);
        idle();
        check(8, rdata, 32'h0);                    // R8 tally restarted

        // R4: saturation on 4-bit instance
        repeat (15 * 16) begin sat_fail = 1'b1; @(negedge clk); end
        sat_fail = 1'b0;
        check(4, sat_rdata, 32'hF);                // R4 reaches ceiling
        repeat (2 * 16) begin sat_fail = 1'b1; @(negedge clk); end
        sat_fail = 1'b0;
        check(4, sat_rdata, 32'hF);                // R4 holds ceiling

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule